// File: doc/BRIEF.md
# Register-Mapped GPIO Controller with Pin Interrupts

This block gives software control over a bank of general-purpose pins through a small synchronous register port. Each pin has a direction bit and an output value. The output value is never written whole: software raises bits through one register and lowers them through another, so two agents can change different pins without a read-modify-write. Pin levels pass through a two-flop synchronizer before anything else in the block sees them. Software reads those synchronized levels back.

Every pin can also raise an interrupt. A type bit picks level or edge sensing, and a polarity bit picks the active level or edge direction. An enable bit arms the detection, and a separate mask bit gates the pin onto the shared interrupt line. Edge events latch until software clears them by writing ones. Level conditions follow the pin. The block has no native both-edge mode. Software gets one by reading the pin level and programming the opposite polarity after each event.

The bus address is a word index, equal to the byte offset divided by four. A read returns data on the clock edge after the address is presented. A write takes effect on the edge where `bus_we` is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` all zero) for both settings of `OE_INV`. `pin_out`, `irq` and the enable, type, polarity, mask and pending registers are all zero.
- R2: Register word indices are: 0 direction, 1 pin level, 3 output set, 4 output clear, 5 interrupt enable, 6 interrupt type, 7 interrupt polarity, 8 interrupt pending, 9 interrupt mask. `bus_rdata` shows the addressed register one cycle after the address. Unlisted indices read 0, and bits at or above `NPINS` read 0.
- R3: Writing to index 3 sets `pin_out` bits where the data bit is 1. A read of index 3 returns the current output values.
- R4: Writing to index 4 clears `pin_out` bits where the data bit is 1. Zero data bits in a set or clear write leave those outputs unchanged. A read of index 4 returns 0.
- R5: With `OE_INV`=0, a direction bit of 1 drives the pin (`pin_oe`=1). With `OE_INV`=1, a direction bit of 1 makes the pin an input, and the direction register resets to all ones.
- R6: Index 1 returns the pin levels after a two-flop synchronizer. A level held for three cycles before the read is returned.
- R7: With type 0 (edge), polarity 1 latches a pending bit on a rising edge and polarity 0 latches it on a falling edge.
- R8: Writing to index 8 clears edge-pending bits where the data bit is 1 and leaves the others set. An edge detected in the same cycle as the clear wins.
- R9: With type 1 (level), a pending bit is 1 exactly while the pin is enabled and its level equals the polarity bit. Writes to index 8 do not affect it.
- R10: `irq` is a register holding the OR of the pending bits whose enable and mask bits are both 1. A masked pin keeps its pending bit visible but does not drive `irq`.
- R11: Reading the pin level and programming the opposite polarity after each event catches both the rising and the falling edge of a pin.
- R12: A pin whose enable bit is 0 latches no edge. Enabling it later does not report an edge that happened while it was disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output values |
| pin_oe | output | NPINS | Output enables, 1 = drive |
| irq | output | 1 | Combined registered interrupt |

## Verification
Edge detection is driven with rising and falling transitions under both polarities. This separates a correctly directed detector from one that fires on any change. Level mode is driven high and low, and the pin is written with a pending clear while its condition still holds, which tells a level-following bit apart from a latched one. Disabled pins are toggled and then enabled, and masked pins are fired, which shows that enable stops detection while mask only gates the line. A software both-edge sequence flips polarity after each event and confirms that each transition is seen exactly once.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_DW = 32;
    localparam int IDX_W  = 4;

    typedef enum logic [IDX_W-1:0] {
        IDX_DIR   = 4'd0,
        IDX_LVL   = 4'd1,
        IDX_SETO  = 4'd3,
        IDX_CLRO  = 4'd4,
        IDX_IEN   = 4'd5,
        IDX_ITYP  = 4'd6,
        IDX_IPOL  = 4'd7,
        IDX_IPEND = 4'd8,
        IDX_IMSK  = 4'd9
    } reg_idx_e;

    typedef struct packed {
        logic              wr;
        reg_idx_e          idx;
        logic [REG_DW-1:0] data;
    } bus_req_t;

    function automatic bit pin_count_ok(int n);
        return (n > 0) && (n < REG_DW);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_irq_pkg::*;
#(
    parameter int NP     = 8,
    parameter bit OE_INV = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [NP-1:0]     lvl,
    input  logic [NP-1:0]     pend,
    output logic [REG_DW-1:0] rdata,
    output logic [NP-1:0]     out,
    output logic [NP-1:0]     oe,
    output logic [NP-1:0]     en,
    output logic [NP-1:0]     typ,
    output logic [NP-1:0]     pol,
    output logic [NP-1:0]     msk,
    output logic              pclr_we,
    output logic [NP-1:0]     pclr_bits
);
    localparam logic [NP-1:0] DIR_RST = OE_INV ? {NP{1'b1}} : {NP{1'b0}};

    logic [NP-1:0] dir_q, out_q, en_q, typ_q, pol_q, msk_q;
    logic [NP-1:0] wbits;
    logic [NP-1:0] rd_word;
    logic          unused_hi;

    assign wbits     = req.data[NP-1:0];
    assign unused_hi = ^req.data[REG_DW-1:NP];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= DIR_RST;
            out_q <= '0;
            en_q  <= '0;
            typ_q <= '0;
            pol_q <= '0;
            msk_q <= '0;
        end else if (req.wr) begin
            case (req.idx)
                IDX_DIR:  dir_q <= wbits;
                IDX_SETO: out_q <= out_q | wbits;
                IDX_CLRO: out_q <= out_q & ~wbits;
                IDX_IEN:  en_q  <= wbits;
                IDX_ITYP: typ_q <= wbits;
                IDX_IPOL: pol_q <= wbits;
                IDX_IMSK: msk_q <= wbits;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (req.idx)
            IDX_DIR:   rd_word = dir_q;
            IDX_LVL:   rd_word = lvl;
            IDX_SETO:  rd_word = out_q;
            IDX_IEN:   rd_word = en_q;
            IDX_ITYP:  rd_word = typ_q;
            IDX_IPOL:  rd_word = pol_q;
            IDX_IPEND: rd_word = pend;
            IDX_IMSK:  rd_word = msk_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= REG_DW'(rd_word);
    end

    assign out       = out_q;
    assign oe        = OE_INV ? ~dir_q : dir_q;
    assign en        = en_q;
    assign typ       = typ_q;
    assign pol       = pol_q;
    assign msk       = msk_q;
    assign pclr_we   = req.wr && (req.idx == IDX_IPEND);
    assign pclr_bits = wbits;

    // R3: written ones end up high
    p_set_drives_high_r3: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.idx == IDX_SETO) |=> ((out_q & $past(wbits)) == $past(wbits)));

    // R4: written ones end up low
    p_clear_drives_low_r4: assert property (@(posedge clk) disable iff (rst)
        (req.wr && req.idx == IDX_CLRO) |=> ((out_q & $past(wbits)) == '0));

    // R4: zero data bits keep their output value
    p_zero_bits_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (req.wr && (req.idx == IDX_SETO || req.idx == IDX_CLRO))
        |=> ((out_q & ~$past(wbits)) == ($past(out_q) & ~$past(wbits))));

    // R1: every pin is an input straight after reset
    p_reset_input_r1: assert property (@(posedge clk)
        $past(rst) |-> (oe == '0));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NP = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] lvl,
    input  logic [NP-1:0] en,
    input  logic [NP-1:0] typ,
    input  logic [NP-1:0] pol,
    input  logic [NP-1:0] msk,
    input  logic          clr_we,
    input  logic [NP-1:0] clr_bits,
    output logic [NP-1:0] pend,
    output logic          irq
);
    logic [NP-1:0] prev_q, edge_q;
    logic [NP-1:0] rise, fall, hit, lvl_pend, clr_vec;
    logic          irq_q;

    assign rise     = lvl & ~prev_q;
    assign fall     = ~lvl & prev_q;
    assign hit      = en & ~typ & ((pol & rise) | (~pol & fall));
    assign lvl_pend = en & typ & ~(lvl ^ pol);
    assign clr_vec  = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            edge_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            prev_q <= lvl;
            edge_q <= (edge_q & ~clr_vec & ~typ) | hit;
            irq_q  <= |(pend & en & msk);
        end
    end

    assign pend = lvl_pend | edge_q;
    assign irq  = irq_q;

    // R12: a new edge latch needs the pin enabled the cycle before
    p_edge_needs_enable_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(en)) == '0));

    // R10: the line is raised only when some pin was enabled and unmasked
    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> $past(|(en & msk)));

    // R8: cleared edge bits stay cleared unless a new edge arrived
    p_pending_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((edge_q & $past(clr_bits) & ~$past(hit)) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter bit OE_INV = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic              bus_we,
    input  logic [REG_DW-1:0] bus_wdata,
    output logic [REG_DW-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);
    bus_req_t         req;
    logic [NPINS-1:0] lvl, pend, en, typ, pol, msk, pclr_bits;
    logic             pclr_we;

    initial assert (pin_count_ok(NPINS)) else $error("NPINS must be 1..31");

    always_comb begin
        req.wr   = bus_we;
        req.idx  = reg_idx_e'(bus_addr);
        req.data = bus_wdata;
    end

    gpio_sync #(.W(NPINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl)
    );

    gpio_regs #(.NP(NPINS), .OE_INV(OE_INV)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .lvl       (lvl),
        .pend      (pend),
        .rdata     (bus_rdata),
        .out       (pin_out),
        .oe        (pin_oe),
        .en        (en),
        .typ       (typ),
        .pol       (pol),
        .msk       (msk),
        .pclr_we   (pclr_we),
        .pclr_bits (pclr_bits)
    );

    gpio_irq_unit #(.NP(NPINS)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .lvl      (lvl),
        .en       (en),
        .typ      (typ),
        .pol      (pol),
        .msk      (msk),
        .clr_we   (pclr_we),
        .clr_bits (pclr_bits),
        .pend     (pend),
        .irq      (irq)
    );

endmodule

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pout0, poe0;
    logic [4:0]  pout1, poe1;
    logic        irq0, irq1;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NPINS(8), .OE_INV(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pin_in(pin_in),
        .pin_out(pout0), .pin_oe(poe0), .irq(irq0));

    gpio_irq_ctrl #(.NPINS(5), .OE_INV(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pin_in(pin_in[4:0]),
        .pin_out(pout1), .pin_oe(poe1), .irq(irq1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_we = 1'b0; pin_in = '0;
        wait_cyc(2);
        rst = 1'b0;
        wait_cyc(1);
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        bus_addr = idx; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] d0, output logic [31:0] d1);
        bus_addr = idx; bus_we = 1'b0;
        @(negedge clk);
        d0 = rdata0; d1 = rdata1;
    endtask

    task automatic t_reset();
        logic [31:0] a, b;
        do_reset();
        chk("R1 oe u0", 32'(poe0), 32'h0);
        chk("R1 oe u1", 32'(poe1), 32'h0);
        chk("R1 out", 32'(pout0), 32'h0);
        chk("R1 irq", 32'(irq0), 32'h0);
        rd(4'd5, a, b); chk("R1 enable reg", a, 32'h0);
        rd(4'd8, a, b); chk("R1 pending reg", a, 32'h0);
        rd(4'd0, a, b); chk("R5 u1 dir reset all ones", b, 32'h1F);
    endtask

    task automatic t_regmap();
        logic [31:0] a, b;
        do_reset();
        wr(4'd5, 32'hFFFF_FFFF);
        rd(4'd5, a, b); chk("R2 enable width u0", a, 32'hFF);
        chk("R2 enable width u1", b, 32'h1F);
        wr(4'd6, 32'h5A); wr(4'd7, 32'hC3); wr(4'd9, 32'h0F);
        rd(4'd6, a, b); chk("R2 type reg", a, 32'h5A);
        rd(4'd7, a, b); chk("R2 pol reg", a, 32'hC3);
        rd(4'd9, a, b); chk("R2 mask reg", a, 32'h0F);
        rd(4'd2, a, b); chk("R2 hole idx2", a, 32'h0);
        rd(4'd10, a, b); chk("R2 hole idx10", a, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] a, b;
        do_reset();
        wr(4'd3, 32'h0000_0081); chk("R3 set", 32'(pout0), 32'h81);
        wr(4'd3, 32'h0000_0004); chk("R4 set keeps zeros", 32'(pout0), 32'h85);
        rd(4'd3, a, b); chk("R3 readback", a, 32'h85);
        wr(4'd4, 32'h0000_0001); chk("R4 clear", 32'(pout0), 32'h84);
        rd(4'd4, a, b); chk("R4 clear reads zero", a, 32'h0);
        wr(4'd0, 32'h0000_0003);
        chk("R5 oe plain", 32'(poe0), 32'h03);
        chk("R5 oe inverted", 32'(poe1), 32'h1C);
    endtask

    task automatic t_input();
        logic [31:0] a, b;
        do_reset();
        pin_in = 8'hA5;
        wait_cyc(3);
        rd(4'd1, a, b); chk("R6 level read", a, 32'hA5);
        chk("R6 level read u1", b, 32'h05);
    endtask

    task automatic t_edge();
        logic [31:0] a, b;
        do_reset();
        wr(4'd6, 32'h0); wr(4'd7, 32'h01); wr(4'd9, 32'h03); wr(4'd5, 32'h03);
        pin_in = 8'h02;           // pin1 rises, polarity 0 ignores it
        wait_cyc(5);
        rd(4'd8, a, b); chk("R7 rise ignored by falling pin", a, 32'h0);
        chk("R10 no irq", 32'(irq0), 32'h0);
        pin_in = 8'h01;           // pin0 rises, pin1 falls
        wait_cyc(5);
        rd(4'd8, a, b); chk("R7 rise and fall latched", a, 32'h03);
        chk("R10 irq high", 32'(irq0), 32'h1);
        pin_in = 8'h00;           // pin0 falls: no new event
        wait_cyc(5);
        wr(4'd8, 32'h01);
        rd(4'd8, a, b); chk("R8 clear one bit only", a, 32'h02);
        wr(4'd8, 32'h02);
        wait_cyc(2);
        rd(4'd8, a, b); chk("R8 all cleared", a, 32'h0);
        chk("R10 irq drops", 32'(irq0), 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] a, b;
        do_reset();
        wr(4'd6, 32'h04); wr(4'd7, 32'h04); wr(4'd5, 32'h04); wr(4'd9, 32'h04);
        pin_in = 8'h04;
        wait_cyc(4);
        rd(4'd8, a, b); chk("R9 level active", a, 32'h04);
        wr(4'd8, 32'h04);
        rd(4'd8, a, b); chk("R9 clear has no effect", a, 32'h04);
        chk("R10 level irq", 32'(irq0), 32'h1);
        pin_in = 8'h00;
        wait_cyc(4);
        rd(4'd8, a, b); chk("R9 level inactive", a, 32'h0);
        chk("R10 level irq drops", 32'(irq0), 32'h0);
    endtask

    task automatic t_mask_enable();
        logic [31:0] a, b;
        do_reset();
        wr(4'd7, 32'h08); wr(4'd9, 32'h08);
        pin_in = 8'h08;           // pin3 disabled
        wait_cyc(5);
        rd(4'd8, a, b); chk("R12 disabled no pending", a, 32'h0);
        wr(4'd5, 32'h08);
        wait_cyc(3);
        rd(4'd8, a, b); chk("R12 no late edge", a, 32'h0);
        chk("R12 no irq", 32'(irq0), 32'h0);
        wr(4'd9, 32'h00);
        pin_in = 8'h00; wait_cyc(3);
        pin_in = 8'h08; wait_cyc(5);
        rd(4'd8, a, b); chk("R10 masked pending visible", a, 32'h08);
        chk("R10 masked no irq", 32'(irq0), 32'h0);
        wr(4'd9, 32'h08);
        wait_cyc(2);
        chk("R10 unmask raises irq", 32'(irq0), 32'h1);
    endtask

    task automatic t_both_edges();
        logic [31:0] a, b, lv;
        do_reset();
        wr(4'd5, 32'h10); wr(4'd9, 32'h10);
        rd(4'd1, lv, b);
        wr(4'd7, ~lv & 32'h10);
        pin_in = 8'h10; wait_cyc(5);
        rd(4'd8, a, b); chk("R11 first edge", a, 32'h10);
        wr(4'd8, 32'h10);
        rd(4'd1, lv, b);
        wr(4'd7, ~lv & 32'h10);
        rd(4'd8, a, b); chk("R11 quiet after flip", a, 32'h0);
        pin_in = 8'h00; wait_cyc(5);
        rd(4'd8, a, b); chk("R11 second edge", a, 32'h10);
        chk("R11 irq", 32'(irq0), 32'h1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        t_reset();
        t_regmap();
        t_output();
        t_input();
        t_edge();
        t_level();
        t_mask_enable();
        t_both_edges();
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < WDOG; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        summary();
        $finish;
    end

endmodule